// File: doc/BRIEF.md
# Tap-Programmable Pulse Generator

This block produces a periodic rectangular pulse. Its high time and its low time are set independently by two tap indices. A ten-stage one-hot ring sequencer moves one step on every clock. A set/reset output register is set when the ring enters step 0 and is cleared when the ring enters the clear tap. When the ring reaches the step just before the end tap, it returns to step 0 on the next clock, so the cycle is shortened to `end_tap_i` steps.

With clear tap T1 and end tap T2, the pulse is high for T1 clocks and low for T2 - T1 clocks. Setting T1 = 5 and T2 = 8 gives 5 clocks high and 3 clocks low. The current step is available as a binary index for observation. Tap settings that are not legal raise an error flag and force the pulse low.

Top module: `tap_pulse_gen`

## Requirements
- R1: While rst_ni is low and after it is released, the block starts at step 0 (step_o = 0) with the output register set. With legal taps, pulse_o is therefore 1.
- R2: Exactly one ring stage is active at any time. When no restart is due, step_o increases by one on each rising clock edge.
- R3: With a legal end tap T2 (1..9), a clock edge in step T2-1 moves the ring to step 0. Step T2 never appears on step_o.
- R4: With legal taps T1 and T2, pulse_o is 1 exactly while step_o < T1. This gives T1 high clocks and T2-T1 low clocks per cycle.
- R5: Entering step 0 sets the output register, so pulse_o is 1 whenever step_o = 0 and the taps are legal.
- R6: tap_err_o is 1 when clr_tap_i is 0, when end_tap_i is 0 or greater than 9, or when clr_tap_i >= end_tap_i. It is 0 otherwise.
- R7: While tap_err_o is 1, pulse_o is held at 0.
- R8: With an end tap outside 1..9, the ring runs through all ten steps and wraps from step 9 to step 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| clr_tap_i | input | 4 | Step whose entry clears the pulse (T1) |
| end_tap_i | input | 4 | Step count of one cycle (T2) |
| pulse_o | output | 1 | Generated pulse |
| step_o | output | 4 | Current ring step as a binary index |
| tap_err_o | output | 1 | Illegal tap setting |

## Verification
The assertions assume the tap inputs do not change in the middle of a cycle. The property that checks the register is set in step 0 also assumes the taps are legal. The stimulus changes the taps only while reset is held and keeps them constant for the whole run that follows. After each release, the expected step, pulse and error values are computed from the tap values. The tap values cover the reference 5/8 setting, both extremes of the legal range, and each class of illegal setting.

// File: rtl/tap_pulse_gen_pkg.sv
package tap_pulse_gen_pkg;
  localparam int unsigned NUM_STEPS = 10;
  localparam int unsigned IDX_W     = $clog2(NUM_STEPS);

  typedef logic [NUM_STEPS-1:0] ring_t;
  typedef logic [IDX_W-1:0]     idx_t;
endpackage

// File: rtl/tpg_tap_check.sv
module tpg_tap_check
  import tap_pulse_gen_pkg::*;
#(
  parameter int unsigned STEPS = NUM_STEPS,
  localparam int unsigned IW   = $clog2(STEPS)
) (
  input  logic [IW-1:0] clr_tap_i,
  input  logic [IW-1:0] end_tap_i,
  output logic          end_ok_o,
  output logic          err_o
);
  logic clr_ok;

  always_comb begin
    end_ok_o = (end_tap_i != '0) && (int'(end_tap_i) <= int'(STEPS) - 1);
    clr_ok   = (clr_tap_i != '0) && (clr_tap_i < end_tap_i);
    err_o    = !(end_ok_o && clr_ok);
  end
endmodule

// File: rtl/tpg_ring.sv
module tpg_ring
#(
  parameter int unsigned STEPS = 10,
  localparam int unsigned IW   = $clog2(STEPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [IW-1:0]    end_tap_i,
  input  logic             end_ok_i,
  output logic [STEPS-1:0] state_o,
  output logic [STEPS-1:0] state_nxt_o
);
  logic [STEPS-1:0] state_q;
  logic             tap_hit;
  logic             wrap;

  // stage just before the end tap
  always_comb begin
    tap_hit = 1'b0;
    for (int i = 0; i < int'(STEPS); i++) begin
      if (int'(end_tap_i) == i + 1) tap_hit = state_q[i];
    end
    wrap = state_q[STEPS-1] | (end_ok_i & tap_hit);
  end

  always_comb begin
    if (wrap) state_nxt_o = {{(STEPS-1){1'b0}}, 1'b1};
    else      state_nxt_o = {state_q[STEPS-2:0], 1'b0};
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) state_q <= {{(STEPS-1){1'b0}}, 1'b1};
    else         state_q <= state_nxt_o;
  end

  assign state_o = state_q;

  p_onehot_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(state_q) == 1);

  p_advance_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !state_q[STEPS-1] && !(end_ok_i && tap_hit) |=> state_q == ($past(state_q) << 1));

  p_restart_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_ok_i && tap_hit |=> state_q[0]);
endmodule

// File: rtl/tpg_out_ff.sv
module tpg_out_ff
#(
  parameter int unsigned STEPS = 10,
  localparam int unsigned IW   = $clog2(STEPS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [STEPS-1:0] state_i,
  input  logic [STEPS-1:0] state_nxt_i,
  input  logic [IW-1:0]    clr_tap_i,
  input  logic             err_i,
  output logic             pulse_o
);
  logic q;
  logic set_en;
  logic clr_en;

  always_comb begin
    set_en = state_nxt_i[0];
    clr_en = 1'b0;
    for (int i = 1; i < int'(STEPS); i++) begin
      if (int'(clr_tap_i) == i) clr_en = state_nxt_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     q <= 1'b1;
    else if (set_en) q <= 1'b1;
    else if (clr_en) q <= 1'b0;
  end

  assign pulse_o = q & ~err_i;

  p_high_at_zero_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    state_i[0] |-> q);

  p_err_low_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_i |-> !pulse_o);
endmodule

// File: rtl/tpg_encode.sv
module tpg_encode
#(
  parameter int unsigned STEPS = 10,
  localparam int unsigned IW   = $clog2(STEPS)
) (
  input  logic [STEPS-1:0] onehot_i,
  output logic [IW-1:0]    idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < int'(STEPS); i++) begin
      if (onehot_i[i]) idx_o = idx_o | IW'(i);
    end
  end
endmodule

// File: rtl/tap_pulse_gen.sv
module tap_pulse_gen
  import tap_pulse_gen_pkg::*;
#(
  parameter int unsigned STEPS = NUM_STEPS,
  localparam int unsigned IW   = $clog2(STEPS)
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [IW-1:0] clr_tap_i,
  input  logic [IW-1:0] end_tap_i,
  output logic          pulse_o,
  output logic [IW-1:0] step_o,
  output logic          tap_err_o
);
  logic [STEPS-1:0] state;
  logic [STEPS-1:0] state_nxt;
  logic             end_ok;

  tpg_tap_check #(.STEPS(STEPS)) i_check (
    .clr_tap_i (clr_tap_i),
    .end_tap_i (end_tap_i),
    .end_ok_o  (end_ok),
    .err_o     (tap_err_o)
  );

  tpg_ring #(.STEPS(STEPS)) i_ring (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .end_tap_i   (end_tap_i),
    .end_ok_i    (end_ok),
    .state_o     (state),
    .state_nxt_o (state_nxt)
  );

  tpg_out_ff #(.STEPS(STEPS)) i_out (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .state_i     (state),
    .state_nxt_i (state_nxt),
    .clr_tap_i   (clr_tap_i),
    .err_i       (tap_err_o),
    .pulse_o     (pulse_o)
  );

  tpg_encode #(.STEPS(STEPS)) i_enc (
    .onehot_i (state),
    .idx_o    (step_o)
  );

  p_step_range_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(step_o) <= int'(STEPS) - 1);

  p_end_unseen_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    end_ok && $stable(end_tap_i) |-> step_o != end_tap_i);
endmodule

// File: tb/test_tap_pulse_gen.sv
module test_tap_pulse_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [3:0] clr_tap = 4'd5;
  logic [3:0] end_tap = 4'd8;
  logic       pulse;
  logic [3:0] step;
  logic       tap_err;

  int total = 0;
  int bad   = 0;

  typedef struct {
    int step;
    bit pulse;
    bit err;
    bit end_ok;
  } exp_t;

  exp_t exp_q[$];

  always #4 clk = ~clk;

  tap_pulse_gen i_tap_pulse_gen (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .clr_tap_i (clr_tap),
    .end_tap_i (end_tap),
    .pulse_o   (pulse),
    .step_o    (step),
    .tap_err_o (tap_err)
  );

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // driver: reset with new taps, then queue expectations for n cycles
  task automatic run_cfg(input int t1, input int t2, input int n);
    bit ok_end;
    bit legal;
    int per;
    wait (exp_q.size() == 0);
    @(negedge clk);
    rst_n   = 1'b0;
    clr_tap = 4'(t1);
    end_tap = 4'(t2);
    ok_end = (t2 >= 1) && (t2 <= 9);
    legal  = ok_end && (t1 >= 1) && (t1 < t2);
    per    = ok_end ? t2 : 10;
    @(negedge clk);
    check(step == 4'd0, "R1 reset step", int'(step), 0);
    check(pulse == legal, "R1 reset pulse", int'(pulse), int'(legal));
    check(tap_err == !legal, "R6 error flag", int'(tap_err), int'(!legal));
    rst_n = 1'b1;
    for (int k = 1; k <= n; k++) begin
      exp_t e;
      e.step   = k % per;
      e.pulse  = legal && (e.step < t1);
      e.err    = !legal;
      e.end_ok = ok_end;
      exp_q.push_back(e);
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(posedge clk);
      #2;
      if (rst_n && exp_q.size() != 0) begin
        exp_t e;
        e = exp_q.pop_front();
        if (e.end_ok) check(int'(step) == e.step, "R2/R3 step", int'(step), e.step);
        else          check(int'(step) == e.step, "R8 wrap step", int'(step), e.step);
        if (e.err) check(pulse == 1'b0, "R7 pulse held low", int'(pulse), 0);
        else       check(pulse == e.pulse, "R4/R5 pulse", int'(pulse), int'(e.pulse));
        check(tap_err == e.err, "R6 error flag", int'(tap_err), int'(e.err));
      end
    end
  end

  initial begin
    int cyc = 0;
    while (cyc < 20000) begin
      @(posedge clk);
      cyc++;
    end
    total++;
    bad++;
    $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    run_cfg(5, 8, 40);   // reference 5 high / 3 low
    run_cfg(1, 2, 20);
    run_cfg(8, 9, 40);
    run_cfg(1, 9, 30);
    run_cfg(3, 4, 20);
    run_cfg(5, 5, 25);   // clear tap not below end tap
    run_cfg(0, 4, 20);   // clear tap zero
    run_cfg(3, 12, 35);  // end tap out of range: full ring
    run_cfg(4, 0, 25);   // end tap zero: full ring
    run_cfg(9, 3, 15);
    run_cfg(2, 6, 30);
    wait (exp_q.size() == 0);
    @(negedge clk);
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule